// File: doc/BRIEF.md
# Signal Register Receiver with Event Classification

This block sits in a device's configuration space and turns 16-bit writes from another bus master into received interrupt events. A write at the signal offset is captured into a small first-in-first-out queue, so several signals that arrive close together are all kept. The word at the head of the queue is decoded on the spot. The decode gives the sender's logical address and sorts the word into one of these classes: a response, one of the three predefined events, a user-defined event with its 6-bit code, or some other event.

A level-sensitive local interrupt stays high while any entry is waiting. Software handles an entry by reading the signal offset, and each such read removes one entry. If a signal arrives while the queue is full and no read happens in the same cycle, the word is dropped and a sticky overflow flag is set. The flag clears when the read that empties the queue is taken.

Top module: `sigrx_top`

## Requirements
- R1: A write (`bus_wr` high) whose address equals SIG_OFFSET (default 8) is captured. A write at any other address changes neither the queue nor any output.
- R2: A head word with bit 15 clear is classed as a response, `sig_class` = 0.
- R3: A head word whose bits 15..8 are 0xFF is classed no-cause (1), 0xFD is classed request-true (2), and 0xFC is classed request-false (3).
- R4: A head word with bit 15 set and bit 14 clear is classed user-defined (4), and `sig_ucode` carries bits 13..8. For every other class `sig_ucode` is 0.
- R5: A head word with bits 15 and 14 both set and bits 15..8 not equal to 0xFF, 0xFD or 0xFC is classed other-event (5).
- R6: `sig_laddr` equals bits 7..0 of the head word, and `sig_word` equals the whole head word.
- R7: `sig_irq` rises in the cycle after an accepted write. It stays high while `sig_count` is non-zero and falls in the cycle after the read that removes the last entry.
- R8: Up to DEPTH (default 4) words are held and presented in arrival order. Each read (`bus_rd` high) at SIG_OFFSET removes exactly one entry.
- R9: A write at SIG_OFFSET while the queue is full and no read is taken in the same cycle drops the word and sets `sig_ovf`. When a read and a write arrive together on a full queue, the head is removed and the new word is kept, and `sig_ovf` is not set.
- R10: Once set, `sig_ovf` stays high until the read that empties the queue.
- R11: A read while the queue is empty, or a read at any other address, has no effect.
- R12: After reset the queue is empty, and `sig_irq` and `sig_ovf` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | ADDR_W | Register offset within the configuration block |
| bus_wdata | input | 16 | Written signal word |
| sig_irq | output | 1 | Local interrupt, high while any entry is queued |
| sig_ovf | output | 1 | Sticky flag: a signal was dropped because the queue was full |
| sig_word | output | 16 | Head entry of the queue |
| sig_class | output | 3 | Class of the head word (0 to 5) |
| sig_laddr | output | 8 | Sender logical address taken from the head word |
| sig_ucode | output | 6 | User event code, valid when the class is 4 |
| sig_count | output | $clog2(DEPTH+1) | Number of queued entries |

## Verification
Some rules are checked by assertions on every cycle. The occupancy never goes above DEPTH, and a taken read with no write lowers it by one. The head stays steady when there is no traffic. A user-defined class always matches bits 15..14 of the head word. An accepted write raises the interrupt, and a dropped write raises the overflow flag. Other behaviour needs the bench's scenarios. These are the exact class codes for each predefined value, arrival order across a full queue, writes at the wrong offset being ignored, reads on an empty queue, the same-cycle read and write on a full queue, and the overflow flag holding until the queue empties.

// File: rtl/sigrx_pkg.sv
package sigrx_pkg;
   localparam int unsigned WORD_W  = 16;
   localparam int unsigned LADDR_W = 8;
   localparam int unsigned UCODE_W = 6;

   typedef enum logic [2:0] {
      CLS_RESPONSE  = 3'd0,
      CLS_NO_CAUSE  = 3'd1,
      CLS_REQ_TRUE  = 3'd2,
      CLS_REQ_FALSE = 3'd3,
      CLS_USER      = 3'd4,
      CLS_OTHER     = 3'd5
   } sig_class_e;

   localparam logic [7:0] HI_NO_CAUSE  = 8'hFF;
   localparam logic [7:0] HI_REQ_TRUE  = 8'hFD;
   localparam logic [7:0] HI_REQ_FALSE = 8'hFC;
endpackage

// File: rtl/sigrx_decode.sv
module sigrx_decode
   import sigrx_pkg::*;
#(
   parameter bit USER_EVT_EN = 1'b1
) (
   input  logic [WORD_W-1:0]  word_i,
   output sig_class_e         class_o,
   output logic [LADDR_W-1:0] laddr_o,
   output logic [UCODE_W-1:0] ucode_o
);
   logic [7:0] hi_byte;
   logic       is_user_fmt;

   assign hi_byte = word_i[15:8];
   assign laddr_o = word_i[LADDR_W-1:0];

   generate
      if (USER_EVT_EN) begin : g_user_on
         assign is_user_fmt = word_i[15] & ~word_i[14];
      end else begin : g_user_off
         assign is_user_fmt = 1'b0;
      end
   endgenerate

   always_comb begin
      if (!word_i[15])                 class_o = CLS_RESPONSE;
      else if (hi_byte == HI_NO_CAUSE)  class_o = CLS_NO_CAUSE;
      else if (hi_byte == HI_REQ_TRUE)  class_o = CLS_REQ_TRUE;
      else if (hi_byte == HI_REQ_FALSE) class_o = CLS_REQ_FALSE;
      else if (is_user_fmt)             class_o = CLS_USER;
      else                              class_o = CLS_OTHER;
   end

   assign ucode_o = (class_o == CLS_USER) ? word_i[13:8] : '0;

   always_comb begin
      AST_USER_CLASS_BITS: assert (class_o != CLS_USER || (word_i[15] && !word_i[14])); // R4
   end
endmodule

// File: rtl/sigrx_fifo.sv
module sigrx_fifo #(
   parameter int unsigned WIDTH = 16,
   parameter int unsigned DEPTH = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         push_i,
   input  logic [WIDTH-1:0]             din_i,
   input  logic                         pop_i,
   output logic [WIDTH-1:0]             head_o,
   output logic [$clog2(DEPTH+1)-1:0]   count_o,
   output logic                         full_o,
   output logic                         empty_o
);
   localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned CNT_W = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("sigrx_fifo: DEPTH must be a power of two, at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PTR_W-1:0] wptr, rptr;
   logic [CNT_W-1:0] count;

   generate
      for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
         always_ff @(posedge clk) begin
            if (push_i && wptr == PTR_W'(gi)) mem[gi] <= din_i;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         if (push_i) wptr <= wptr + 1'b1;
         if (pop_i)  rptr <= rptr + 1'b1;
         if (push_i && !pop_i)      count <= count + 1'b1;
         else if (pop_i && !push_i) count <= count - 1'b1;
      end
   end

   assign head_o  = (count == '0) ? '0 : mem[rptr];
   assign count_o = count;
   assign full_o  = (count == CNT_W'(DEPTH));
   assign empty_o = (count == '0);

   AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH)); // R8
   AST_POP_DECREMENTS: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_i && !push_i && count != '0) |=> count == $past(count) - 1'b1); // R8
   AST_HEAD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!push_i && !pop_i && count != '0) |=> $stable(head_o)); // R8
endmodule

// File: rtl/sigrx_top.sv
module sigrx_top
   import sigrx_pkg::*;
#(
   parameter int unsigned ADDR_W      = 6,
   parameter int unsigned SIG_OFFSET  = 8,
   parameter int unsigned DEPTH       = 4,
   parameter bit          USER_EVT_EN = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        bus_wr,
   input  logic                        bus_rd,
   input  logic [ADDR_W-1:0]           bus_addr,
   input  logic [15:0]                 bus_wdata,
   output logic                        sig_irq,
   output logic                        sig_ovf,
   output logic [15:0]                 sig_word,
   output logic [2:0]                  sig_class,
   output logic [7:0]                  sig_laddr,
   output logic [5:0]                  sig_ucode,
   output logic [$clog2(DEPTH+1)-1:0]  sig_count
);
   localparam int unsigned CNT_W = $clog2(DEPTH + 1);

   generate
      if (SIG_OFFSET >= (1 << ADDR_W)) begin : g_bad_offset
         $error("sigrx_top: SIG_OFFSET does not fit in ADDR_W");
      end
   endgenerate

   logic       addr_hit, wr_hit, rd_hit, push, pop, full, empty;
   logic [CNT_W-1:0] count;
   logic [WORD_W-1:0] head;
   sig_class_e head_class;

   assign addr_hit = (bus_addr == ADDR_W'(SIG_OFFSET));
   assign wr_hit   = bus_wr & addr_hit;
   assign rd_hit   = bus_rd & addr_hit;
   assign pop      = rd_hit & ~empty;
   assign push     = wr_hit & (~full | pop);

   sigrx_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) i_fifo (
      .clk(clk), .rst_n(rst_n), .push_i(push), .din_i(bus_wdata),
      .pop_i(pop), .head_o(head), .count_o(count), .full_o(full), .empty_o(empty)
   );

   sigrx_decode #(.USER_EVT_EN(USER_EVT_EN)) i_decode (
      .word_i(head), .class_o(head_class), .laddr_o(sig_laddr), .ucode_o(sig_ucode)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                       sig_ovf <= 1'b0;
      else if (wr_hit && full && !pop)                  sig_ovf <= 1'b1;
      else if (pop && !push && count == CNT_W'(1))      sig_ovf <= 1'b0;
   end

   assign sig_irq   = ~empty;
   assign sig_word  = head;
   assign sig_class = head_class;
   assign sig_count = count;

   AST_IRQ_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit |=> sig_irq); // R7
   AST_OVF_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && full && !rd_hit) |=> sig_ovf); // R9
   AST_WRONG_OFFSET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!addr_hit) |=> $stable(sig_count)); // R1
endmodule

// File: tb/test_sigrx_top.sv
module test_sigrx_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic        sig_irq, sig_ovf;
   logic [15:0] sig_word;
   logic [2:0]  sig_class;
   logic [7:0]  sig_laddr;
   logic [5:0]  sig_ucode;
   logic [2:0]  sig_count;

   int checks = 0, failures = 0;
   bit done = 1'b0;
   logic [15:0] exp_q[$];
   bit model_ovf = 1'b0;

   always #10 clk = ~clk;

   sigrx_top i_sigrx_top (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .sig_irq(sig_irq),
      .sig_ovf(sig_ovf), .sig_word(sig_word), .sig_class(sig_class),
      .sig_laddr(sig_laddr), .sig_ucode(sig_ucode), .sig_count(sig_count)
   );

   function automatic logic [2:0] exp_class(input logic [15:0] w);
      if (!w[15])             return 3'd0;
      if (w[15:8] == 8'hFF)   return 3'd1;
      if (w[15:8] == 8'hFD)   return 3'd2;
      if (w[15:8] == 8'hFC)   return 3'd3;
      if (!w[14])             return 3'd4;
      return 3'd5;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Monitor side of the scoreboard: compares outputs against the queue front.
   task automatic monitor(input string req);
      chk({req, " irq R7"}, sig_irq, exp_q.size() != 0);
      chk({req, " count R8"}, sig_count, exp_q.size());
      chk({req, " ovf R10"}, sig_ovf, model_ovf);
      if (exp_q.size() != 0) begin
         chk({req, " word R6"}, sig_word, exp_q[0]);
         chk({req, " laddr R6"}, sig_laddr, exp_q[0][7:0]);
         chk({req, " class R2"}, sig_class, exp_class(exp_q[0]));
         chk({req, " ucode R4"}, sig_ucode,
             exp_class(exp_q[0]) == 3'd4 ? {26'd0, exp_q[0][13:8]} : 32'd0);
      end
   endtask

   // Driver: one bus cycle; updates expected queue from the requirements.
   task automatic bus_cycle(input bit wr, input bit rd, input logic [5:0] a, input logic [15:0] d);
      bit hit = (a == 6'd8);
      bit popped = 1'b0;
      @(negedge clk);
      bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_rd = 1'b0;
      if (hit && rd && exp_q.size() != 0) begin
         void'(exp_q.pop_front());
         popped = 1'b1;
      end
      if (hit && wr) begin
         if (exp_q.size() < 4) exp_q.push_back(d);
         else model_ovf = 1'b1;
      end
      if (popped && exp_q.size() == 0) model_ovf = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("reset irq R12", sig_irq, 0);
      chk("reset ovf R12", sig_ovf, 0);
      chk("reset count R12", sig_count, 0);
      rst_n = 1'b1;
      @(negedge clk);

      bus_cycle(1, 0, 6'd8, 16'h1234);   monitor("response R2");
      chk("irq after write R7", sig_irq, 1);
      bus_cycle(0, 1, 6'd8, 16'h0);      monitor("pop last R7");
      chk("irq low after pop R7", sig_irq, 0);

      bus_cycle(1, 0, 6'd4, 16'hFF01);   monitor("wrong offset write R1");
      chk("ignored write count R1", sig_count, 0);
      bus_cycle(0, 1, 6'd8, 16'h0);      monitor("empty read R11");

      bus_cycle(1, 0, 6'd8, 16'hFF05);   monitor("no-cause R3");
      chk("no-cause class R3", sig_class, 1);
      bus_cycle(1, 0, 6'd8, 16'hFD06);   monitor("fill2 R8");
      bus_cycle(1, 0, 6'd8, 16'hFC07);   monitor("fill3 R8");
      bus_cycle(1, 0, 6'd8, 16'hAA09);   monitor("fill4 R8");
      bus_cycle(1, 0, 6'd8, 16'hC10A);   monitor("drop when full R9");
      chk("ovf set R9", sig_ovf, 1);
      bus_cycle(0, 1, 6'd2, 16'h0);      monitor("read other offset R11");
      chk("wrong-offset read keeps count R11", sig_count, 4);
      bus_cycle(0, 1, 6'd8, 16'h0);      monitor("req-true head R3");
      chk("req-true class R3", sig_class, 2);
      bus_cycle(0, 1, 6'd8, 16'h0);      monitor("req-false head R3");
      chk("req-false class R3", sig_class, 3);
      chk("ovf holds R10", sig_ovf, 1);
      bus_cycle(0, 1, 6'd8, 16'h0);      monitor("user head R4");
      chk("user class R4", sig_class, 4);
      chk("user code R4", sig_ucode, 6'h2A);
      bus_cycle(0, 1, 6'd8, 16'h0);      monitor("emptied R10");
      chk("ovf cleared R10", sig_ovf, 0);

      bus_cycle(1, 0, 6'd8, 16'hC10A);   monitor("other event R5");
      chk("other class R5", sig_class, 5);
      chk("other ucode R4", sig_ucode, 0);
      bus_cycle(1, 0, 6'd8, 16'hBF11);   monitor("fill R8");
      bus_cycle(1, 0, 6'd8, 16'h7E22);   monitor("fill R8");
      bus_cycle(1, 0, 6'd8, 16'hFE33);   monitor("fill R8");
      bus_cycle(1, 1, 6'd8, 16'h8044);   monitor("full read+write R9");
      chk("no ovf on read+write R9", sig_ovf, 0);
      chk("count stays full R9", sig_count, 4);
      for (int i = 0; i < 4; i++) begin
         bus_cycle(0, 1, 6'd8, 16'h0);   monitor("drain R8");
      end
      chk("drained irq R7", sig_irq, 0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule